// File: doc/BRIEF.md
# Endpoint Transmit Path with Debug-Host Address Insertion

This block is the outgoing half of a network endpoint. A processing element hands it packets one word at a time, and it passes them on to the network. Each word comes with a kind tag. A packet is a run of destination address words, then payload words, then one end-of-packet command word.

When debug mirroring is enabled for this endpoint, the block adds one more destination address to the packet. That address is the one held in the debug-host register. The multicast routers further on then deliver the unchanged packet to its original destinations and a duplicate to the debug host. Mirroring is switched per endpoint through a small register write port.

The block stores each packet before forwarding it, because the length limit can only be judged once the end-of-packet word has arrived. This lets it skip the insertion when there is no room for it. Inputs are held off while a stored packet drains.

Top module: `ep_dbg_tx`

## Requirements
- R1: With mirroring disabled, the words leaving the block are those of the incoming packet, in the same order, with the same kind tags. Kind tags are 0 for an address word, 1 for a payload word and 2 for the end-of-packet word.
- R2: With mirroring enabled, one word of kind 0 carrying the debug-host address is emitted directly after the last incoming address word and before the first payload word. If the packet has no address words, it is emitted first. All other words keep their order and value.
- R3: If an incoming address word already equals the debug-host address, nothing is inserted.
- R4: No packet leaves the block longer than MAX_WORDS words. A packet that would reach exactly MAX_WORDS with the insertion still gets the insertion. A packet whose insertion would exceed the limit is sent unmodified and sets the overflow flag.
- R5: The overflow flag stays set until reset.
- R6: The enable bit and the host address are sampled when the first word of a packet is accepted. A write during a packet applies from the next packet on.
- R7: While the output is valid and not accepted, the output word and its kind stay stable. No input word is accepted while a stored packet is being forwarded.
- R8: After reset, no output is valid, input is ready, the overflow flag is clear and mirroring is disabled.
- R9: The write port treats select 0 as the enable bit, taken from bit 0 of the write data. It treats select 1 as the full host address word. An address word holds the system field in its top bits, the cluster field in the middle and the group field in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable bit, 1 selects host address |
| cfg_wdata | input | W | Register write data |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Block accepts an incoming word |
| in_kind | input | 2 | Incoming word kind tag |
| in_data | input | W | Incoming word |
| out_valid | output | 1 | Outgoing word valid |
| out_ready | input | 1 | Network accepts the outgoing word |
| out_kind | output | 2 | Outgoing word kind tag |
| out_data | output | W | Outgoing word |
| dbg_ovf | output | 1 | Sticky flag: an insertion was skipped for length |

## Verification
The bench builds the block with its defaults: three 8-bit address fields and a 32-word packet limit. With these values a 31-word packet, which grows to exactly the limit, and a 32-word packet, which must refuse the insertion, are both short enough to drive directly. Mid-packet register writes and held-off output beats are directed cases around the vector table.

// File: rtl/ep_dbg_pkg.sv
package ep_dbg_pkg;
  localparam logic [1:0] KIND_ADDR = 2'd0;
  localparam logic [1:0] KIND_DATA = 2'd1;
  localparam logic [1:0] KIND_EOP  = 2'd2;

  // True when a packet of len words can take one extra word within maxw.
  function automatic bit room_for_one(input int len, input int maxw);
    return (len + 1) <= maxw;
  endfunction

  // Buffer index feeding output position oidx when an extra word sits at slot.
  function automatic int src_index(input int oidx, input int slot, input bit ins);
    return (ins && oidx > slot) ? oidx - 1 : oidx;
  endfunction
endpackage

// File: rtl/ep_dbg_cfg.sv
module ep_dbg_cfg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic         en,
  output logic [W-1:0] host
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      host <= '0;
    end else if (we) begin
      if (sel) host <= wdata;
      else     en   <= wdata[0];
    end
  end
endmodule

// File: rtl/ep_dbg_buf.sv
module ep_dbg_buf #(
  parameter int W     = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wkind,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [1:0]    rkind,
  output logic [W-1:0]  rdata
);
  logic [W+1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wkind, wdata};
  end

  assign {rkind, rdata} = mem[raddr];
endmodule

// File: rtl/ep_dbg_tx.sv
module ep_dbg_tx
  import ep_dbg_pkg::*;
#(
  parameter int GRP_W     = 8,
  parameter int CLU_W     = 8,
  parameter int SYS_W     = 8,
  parameter int MAX_WORDS = 32,
  localparam int W  = SYS_W + CLU_W + GRP_W,
  localparam int CW = $clog2(MAX_WORDS + 1),
  localparam int AW = $clog2(MAX_WORDS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic         cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_kind,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [1:0]   out_kind,
  output logic [W-1:0] out_data,
  output logic         dbg_ovf
);
  typedef enum logic {ST_CAP, ST_SEND} st_e;

  st_e           st;
  logic [CW-1:0] wcnt, acnt, olen, oidx;
  logic          seen, snap_en, ins_q;
  logic [W-1:0]  snap_host;

  logic         cfg_en;
  logic [W-1:0] cfg_host;

  ep_dbg_cfg #(.W(W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .en(cfg_en), .host(cfg_host)
  );

  // Named internal events
  logic          in_fire, out_fire, first_w, last_in, last_out;
  logic          cur_en, hit, want, fits, ins_next, ovf_evt, dbg_slot;
  logic [W-1:0]  cur_host;
  logic [CW-1:0] len_now;
  logic [AW-1:0] raddr;
  logic [1:0]    rkind;
  logic [W-1:0]  rdata;

  assign in_ready  = (st == ST_CAP);
  assign out_valid = (st == ST_SEND);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign first_w   = (wcnt == '0);
  assign cur_en    = first_w ? cfg_en : snap_en;
  assign cur_host  = first_w ? cfg_host : snap_host;
  assign hit       = (in_kind == KIND_ADDR) && (in_data == cur_host);
  assign len_now   = wcnt + CW'(1);
  assign last_in   = in_fire && ((in_kind == KIND_EOP) || (wcnt == CW'(MAX_WORDS - 1)));
  assign want      = cur_en && !(seen || hit);
  assign fits      = room_for_one(int'(len_now), MAX_WORDS);
  assign ins_next  = want && fits;
  assign ovf_evt   = last_in && want && !fits;
  assign dbg_slot  = ins_q && (oidx == acnt);
  assign last_out  = out_fire && (oidx == olen - CW'(1));
  assign raddr     = AW'(src_index(int'(oidx), int'(acnt), ins_q));

  ep_dbg_buf #(.W(W), .DEPTH(MAX_WORDS)) buf_i (
    .clk(clk), .we(in_fire), .waddr(wcnt[AW-1:0]), .wkind(in_kind),
    .wdata(in_data), .raddr(raddr), .rkind(rkind), .rdata(rdata)
  );

  assign out_data = dbg_slot ? snap_host : rdata;
  assign out_kind = dbg_slot ? KIND_ADDR : rkind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_CAP;
      wcnt      <= '0;
      acnt      <= '0;
      olen      <= '0;
      oidx      <= '0;
      seen      <= 1'b0;
      snap_en   <= 1'b0;
      snap_host <= '0;
      ins_q     <= 1'b0;
      dbg_ovf   <= 1'b0;
    end else begin
      if (in_fire) begin
        wcnt <= len_now;
        if (first_w) begin
          snap_en   <= cfg_en;
          snap_host <= cfg_host;
        end
        if (in_kind == KIND_ADDR) acnt <= acnt + CW'(1);
        if (hit) seen <= 1'b1;
      end
      if (last_in) begin
        st    <= ST_SEND;
        olen  <= len_now + CW'(ins_next);
        ins_q <= ins_next;
        oidx  <= '0;
      end
      if (ovf_evt) dbg_ovf <= 1'b1;
      if (out_fire) oidx <= oidx + CW'(1);
      if (last_out) begin
        st    <= ST_CAP;
        wcnt  <= '0;
        acnt  <= '0;
        seen  <= 1'b0;
        ins_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ep_dbg_tx_chk.sv
module ep_dbg_tx_chk
  import ep_dbg_pkg::*;
#(
  parameter int W         = 24,
  parameter int MAX_WORDS = 32,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [1:0]   out_kind,
  input logic [W-1:0] out_data,
  input logic         dbg_ovf,
  input logic         ovf_evt
);
  logic [CW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else if (out_valid && out_ready) begin
      if (out_kind == KIND_EOP) pcnt <= '0;
      else                      pcnt <= pcnt + CW'(1);
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));

  assert_no_accept_while_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ovf |=> dbg_ovf);

  assert_no_overlen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pcnt < CW'(MAX_WORDS)));

  assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_ovf) |-> $past(ovf_evt && in_valid && in_ready));
endmodule

bind ep_dbg_tx ep_dbg_tx_chk #(.W(W), .MAX_WORDS(MAX_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_data(out_data), .dbg_ovf(dbg_ovf), .ovf_evt(ovf_evt)
);

// File: tb/ep_dbg_tx_tb_top.sv
`timescale 1ns/1ps
module ep_dbg_tx_tb_top;
  import ep_dbg_pkg::*;
  localparam int W = 24;
  localparam int MAXW = 32;
  localparam logic [W-1:0] HOST_A = 24'hABCDEF;
  localparam logic [W-1:0] HOST_B = 24'h5A5A01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_kind = '0;
  logic [W-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] out_kind;
  logic [W-1:0] out_data;
  logic dbg_ovf;

  always #2 clk = ~clk;

  ep_dbg_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_data(out_data),
    .dbg_ovf(dbg_ovf)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Table: address words, payload words, enable, host already listed, expected length, expected flag
  localparam int NV = 9;
  localparam int T_NA  [NV] = '{2, 2, 1, 3, 0, 4, 5, 2, 2};
  localparam int T_ND  [NV] = '{3, 3, 0, 4, 2, 26, 26, 2, 2};
  localparam int T_EN  [NV] = '{0, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int T_DUP [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int T_OLEN[NV] = '{6, 7, 3, 8, 4, 32, 32, 5, 6};
  localparam int T_OVF [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1};

  logic [1:0]   pk_k [64];
  logic [W-1:0] pk_d [64];
  int           pk_n, pk_na;
  logic [1:0]   ex_k [64];
  logic [W-1:0] ex_d [64];
  int           ex_n;
  logic [1:0]   got_k [64];
  logic [W-1:0] got_d [64];
  int           got_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input int na, input int nd, input bit dup, input int tag, input logic [W-1:0] host);
    pk_n = 0;
    pk_na = na;
    for (int i = 0; i < na; i++) begin
      pk_k[pk_n] = KIND_ADDR;
      pk_d[pk_n] = (dup && i == 0) ? host : {8'(i + 1), 8'(16 + tag), 8'(32 + i)};
      pk_n++;
    end
    for (int j = 0; j < nd; j++) begin
      pk_k[pk_n] = KIND_DATA;
      pk_d[pk_n] = W'(tag * 256 + j);
      pk_n++;
    end
    pk_k[pk_n] = KIND_EOP;
    pk_d[pk_n] = W'(24'hE0F000 + tag);
    pk_n++;
  endtask

  task automatic expect_pkt(input bit ins, input logic [W-1:0] host);
    ex_n = 0;
    for (int i = 0; i < pk_n; i++) begin
      if (ins && i == pk_na) begin
        ex_k[ex_n] = KIND_ADDR;
        ex_d[ex_n] = host;
        ex_n++;
      end
      ex_k[ex_n] = pk_k[i];
      ex_d[ex_n] = pk_d[i];
      ex_n++;
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [W-1:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_word(input logic [1:0] k, input logic [W-1:0] d);
    in_valid = 1'b1; in_kind = k; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_range(input int from, input int upto);
    for (int i = from; i < upto; i++) send_word(pk_k[i], pk_d[i]);
  endtask

  task automatic recv_pkt();
    got_n = 0;
    out_ready = 1'b1;
    for (int g = 0; g < 64; g++) begin
      while (!out_valid) @(negedge clk);
      got_k[got_n] = out_kind;
      got_d[got_n] = out_data;
      got_n++;
      @(negedge clk);
      if (got_k[got_n - 1] == KIND_EOP) break;
    end
    out_ready = 1'b0;
  endtask

  task automatic compare(input string req);
    chk(got_n == ex_n, req, "length", got_n, ex_n);
    for (int i = 0; i < ex_n && i < got_n; i++) begin
      chk(got_k[i] == ex_k[i], req, $sformatf("kind[%0d]", i), int'(got_k[i]), int'(ex_k[i]));
      chk(got_d[i] == ex_d[i], req, $sformatf("word[%0d]", i), int'(got_d[i]), int'(ex_d[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8", "out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready", int'(in_ready), 1);
    chk(dbg_ovf == 1'b0, "R8", "dbg_ovf", int'(dbg_ovf), 0);

    // Vector table (R1, R2, R3, R4, R5, R9)
    for (int v = 0; v < NV; v++) begin
      cfg_write(1'b1, HOST_A);
      cfg_write(1'b0, W'(T_EN[v]));
      build(T_NA[v], T_ND[v], T_DUP[v] != 0, v, HOST_A);
      expect_pkt(T_OLEN[v] == pk_n + 1, HOST_A);
      send_range(0, pk_n);
      recv_pkt();
      compare($sformatf("R1/R2/R3/R4 row%0d", v));
      chk(got_n == T_OLEN[v], "R4", $sformatf("row%0d out length", v), got_n, T_OLEN[v]);
      chk(dbg_ovf == T_OVF[v][0], "R5", $sformatf("row%0d overflow flag", v), int'(dbg_ovf), T_OVF[v]);
    end

    // R8: second reset clears the sticky flag and the enable bit
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dbg_ovf == 1'b0, "R8", "flag after reset", int'(dbg_ovf), 0);
    build(2, 2, 1'b0, 40, HOST_A);
    expect_pkt(1'b0, HOST_A);
    send_range(0, pk_n);
    recv_pkt();
    compare("R8 mirroring off after reset");

    // R6: enable written in mid-packet applies only to the next packet
    cfg_write(1'b1, HOST_A);
    build(2, 3, 1'b0, 41, HOST_A);
    expect_pkt(1'b0, HOST_A);
    send_word(pk_k[0], pk_d[0]);
    cfg_write(1'b0, W'(1));
    send_range(1, pk_n);
    recv_pkt();
    compare("R6 enable mid-packet");
    build(2, 3, 1'b0, 42, HOST_A);
    expect_pkt(1'b1, HOST_A);
    send_range(0, pk_n);
    recv_pkt();
    compare("R6 enable next packet");

    // R6: host address written in mid-packet; old one still inserted
    build(1, 2, 1'b0, 43, HOST_A);
    expect_pkt(1'b1, HOST_A);
    send_word(pk_k[0], pk_d[0]);
    cfg_write(1'b1, HOST_B);
    send_range(1, pk_n);
    recv_pkt();
    compare("R6 host mid-packet");

    // R7: back-pressure holds the output and blocks input
    build(1, 1, 1'b0, 44, HOST_B);
    expect_pkt(1'b1, HOST_B);
    send_range(0, pk_n);
    out_ready = 1'b0;
    @(negedge clk);
    begin
      logic [W-1:0] d0;
      logic [1:0] k0;
      d0 = out_data;
      k0 = out_kind;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
      chk(out_data == d0 && out_kind == k0, "R7", "word held", int'(out_data), int'(d0));
      chk(in_ready == 1'b0, "R7", "input blocked", int'(in_ready), 0);
    end
    recv_pkt();
    compare("R7 after stall");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule